// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic Unit With Overflow Word

This block evaluates one two-operand instruction at a time for a small 16-bit processor. Each instruction is a 4-bit opcode and two data words, `a` and `b`. Instead of carry or borrow flags, the arithmetic opcodes produce a second full-width word, the overflow word, whose meaning depends on the opcode. A separate write strobe qualifies that word. The four test opcodes produce a single condition flag. Every completed instruction also reports its fixed cost in processor cycles, so the sequencer can keep its cycle count.

A caller pulses `start` with the opcode and operands. For most opcodes the results are registered and appear with a one-cycle `done` pulse on the next clock. Division and remainder share one restoring divider. That divider runs one quotient bit per clock, and `busy` stays high until it finishes. A `start` seen while `busy` is high is dropped. Fetching operands, steering results back to registers, and skipping instructions are left to the surrounding pipeline.

Top module: `ovw_alu`

## Requirements
- R1: After a synchronous active-low reset, `done`, `busy`, `result_we`, `ovf_we` and `cond_true` are 0, and `result` and `ovf_word` are 0.
- R2: Opcodes 0x1 (copy: result=b), 0x9 (a AND b), 0xA (a OR b) and 0xB (a XOR b) raise `result_we`, leave `ovf_we` low and drive `ovf_word` to 0.
- R3: Opcode 0x2 gives (a+b) mod 2^16, with an overflow word of 0x0001 on carry out and 0x0000 otherwise. Opcode 0x3 gives (a-b) mod 2^16, with an overflow word of 0xFFFF when b>a and 0x0000 otherwise. Both raise `result_we` and `ovf_we`.
- R4: Opcode 0x4 returns the low 16 bits of the 32-bit product as the result and the high 16 bits as the overflow word. It raises both strobes.
- R5: Opcode 0x7 returns (a<<b) mod 2^16 as the result and (a<<b)>>16 as the overflow word. Opcode 0x8 returns a>>b as the result and ((a<<16)>>b) mod 2^16 as the overflow word. A shift amount of 32 or more gives 0 for both. Both opcodes raise both strobes.
- R6: Opcode 0x5 returns a/b as the result and ((a<<16)/b) mod 2^16 as the overflow word. Both are 0 when b is 0. It raises both strobes.
- R7: Opcode 0x6 returns a%b, or 0 when b is 0. It raises `result_we`, keeps `ovf_we` low and drives `ovf_word` to 0.
- R8: Opcodes 0xC (a==b), 0xD (a!=b), 0xE (a>b unsigned) and 0xF ((a AND b)!=0) set `cond_true` to the test outcome. Neither strobe is raised, and `result` and `ovf_word` are 0.
- R9: With `done`, `cycle_cost` is 1 for opcodes 0x1, 0x9, 0xA and 0xB; 2 for 0x2, 0x3, 0x4, 0x7, 0x8 and 0xC to 0xF; 3 for 0x5 and 0x6; and 0 for opcode 0x0.
- R10: `done` rises one cycle after the clock edge that accepts `start` for every opcode except 0x5 and 0x6. For 0x5 and 0x6 it rises 2*WIDTH+2 cycles after that edge (34 at the default width), and `busy` is high in between. A `start` while `busy` is high has no effect.
- R11: Opcode 0x0 completes in one cycle with no write strobe, `cond_true` low, and `result` and `ovf_word` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept an instruction this cycle (ignored while busy) |
| opcode | input | 4 | Instruction code |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| busy | output | 1 | Divider running; new starts are dropped |
| done | output | 1 | One-cycle pulse: outputs below are valid |
| result | output | 16 | Result word |
| result_we | output | 1 | Result should be written back |
| ovf_word | output | 16 | Overflow word |
| ovf_we | output | 1 | Overflow word should be written back |
| cond_true | output | 1 | Outcome of a test opcode |
| cycle_cost | output | 2 | Instruction cost in processor cycles |

## Verification
Every result, strobe, flag and cost is due together on the single cycle in which `done` is high. For non-dividing opcodes that is the first cycle after the accepting edge; for the divider opcodes it is cycle 34. The bench drives inputs on the falling edge and counts falling edges after `start` until `done` appears. It checks that count against the expected latency and samples all outputs on that same falling edge, never at a rising edge. The dropped-start case is checked by driving a second `start` partway through a division. The bench then confirms that the division values still arrive on cycle 34 and that no further `done` follows.

// File: rtl/ovw_alu_pkg.sv
// Shared opcode encoding and cost table for the overflow-word ALU.
// Assumes a 4-bit opcode field; the numeric codes are fixed by the
// instruction encoding decoded upstream.
package ovw_alu_pkg;

    localparam int OPC_W  = 4;
    localparam int COST_W = 2;

    typedef enum logic [OPC_W-1:0] {
        OPC_NONE = 4'h0,
        OPC_MOV  = 4'h1,
        OPC_ADD  = 4'h2,
        OPC_SUB  = 4'h3,
        OPC_MUL  = 4'h4,
        OPC_DIV  = 4'h5,
        OPC_REM  = 4'h6,
        OPC_SHL  = 4'h7,
        OPC_SHR  = 4'h8,
        OPC_AND  = 4'h9,
        OPC_OR   = 4'hA,
        OPC_XOR  = 4'hB,
        OPC_TEQ  = 4'hC,
        OPC_TNE  = 4'hD,
        OPC_TGT  = 4'hE,
        OPC_TBIT = 4'hF
    } opcode_t;

    // Fixed processor-cycle cost of each opcode.
    function automatic logic [COST_W-1:0] op_cost(input logic [OPC_W-1:0] op);
        logic [COST_W-1:0] c;
        case (op)
            OPC_NONE:                         c = 2'd0;
            OPC_MOV, OPC_AND, OPC_OR, OPC_XOR: c = 2'd1;
            OPC_DIV, OPC_REM:                 c = 2'd3;
            default:                          c = 2'd2;
        endcase
        return c;
    endfunction

    // True for the opcodes served by the iterative divider.
    function automatic logic uses_divider(input logic [OPC_W-1:0] op);
        return (op == OPC_DIV) || (op == OPC_REM);
    endfunction

endpackage

// File: rtl/ovw_alu_shifter.sv
// Double-width logical shifter for the shift opcodes.
// Produces both halves of (a << n) and of ({a,0} >> n). Any shift
// amount at or above twice the width yields zero.
// Assumes WIDTH is a power of two, so that 2*WIDTH is one too.
module ovw_alu_shifter #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] val,
    input  logic [WIDTH-1:0] amt,
    output logic [WIDTH-1:0] left_lo,
    output logic [WIDTH-1:0] left_hi,
    output logic [WIDTH-1:0] right_hi,
    output logic [WIDTH-1:0] right_lo
);
    localparam int DW   = 2 * WIDTH;
    localparam int SH_W = $clog2(DW);

    logic          too_far;
    logic [DW-1:0] wide_left;
    logic [DW-1:0] wide_right;

    // Any bit at or above position SH_W means the amount reaches 2*WIDTH.
    assign too_far = (amt >> SH_W) != '0;

    // Shift the zero-extended value left and the value-over-zeros right.
    always_comb begin
        wide_left  = {{WIDTH{1'b0}}, val} << amt[SH_W-1:0];
        wide_right = {val, {WIDTH{1'b0}}} >> amt[SH_W-1:0];
        if (too_far) begin
            wide_left  = '0;
            wide_right = '0;
        end
    end

    assign left_lo  = wide_left[WIDTH-1:0];
    assign left_hi  = wide_left[DW-1:WIDTH];
    assign right_hi = wide_right[DW-1:WIDTH];
    assign right_lo = wide_right[WIDTH-1:0];

endmodule

// File: rtl/ovw_alu_unit.sv
// Combinational evaluation of every opcode that finishes in one cycle.
// The divider opcodes and opcode 0 yield zeros and no strobes here;
// the top level supplies the divider results.
module ovw_alu_unit
    import ovw_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [OPC_W-1:0] op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] res,
    output logic             res_we,
    output logic [WIDTH-1:0] ovf,
    output logic             ovf_we,
    output logic             cond
);
    localparam int DW = 2 * WIDTH;

    logic [WIDTH:0]   sum_x;
    logic [WIDTH:0]   diff_x;
    logic [DW-1:0]    prod;
    logic [WIDTH-1:0] shl_lo, shl_hi, shr_hi, shr_lo;

    // Extended-width adder, subtractor and multiplier.
    assign sum_x  = {1'b0, a} + {1'b0, b};
    assign diff_x = {1'b0, a} - {1'b0, b};
    assign prod   = DW'(a) * DW'(b);

    ovw_alu_shifter #(.WIDTH(WIDTH)) shifter_i (
        .val      (a),
        .amt      (b),
        .left_lo  (shl_lo),
        .left_hi  (shl_hi),
        .right_hi (shr_hi),
        .right_lo (shr_lo)
    );

    // Select result, overflow word, strobes and test outcome per opcode.
    always_comb begin
        res    = '0;
        res_we = 1'b0;
        ovf    = '0;
        ovf_we = 1'b0;
        cond   = 1'b0;
        case (op)
            OPC_MOV: begin res = b;      res_we = 1'b1; end
            OPC_AND: begin res = a & b;  res_we = 1'b1; end
            OPC_OR:  begin res = a | b;  res_we = 1'b1; end
            OPC_XOR: begin res = a ^ b;  res_we = 1'b1; end
            OPC_ADD: begin
                res    = sum_x[WIDTH-1:0];
                ovf    = WIDTH'(sum_x[WIDTH]);
                res_we = 1'b1;
                ovf_we = 1'b1;
            end
            OPC_SUB: begin
                res    = diff_x[WIDTH-1:0];
                ovf    = {WIDTH{diff_x[WIDTH]}};
                res_we = 1'b1;
                ovf_we = 1'b1;
            end
            OPC_MUL: begin
                res    = prod[WIDTH-1:0];
                ovf    = prod[DW-1:WIDTH];
                res_we = 1'b1;
                ovf_we = 1'b1;
            end
            OPC_SHL: begin
                res    = shl_lo;
                ovf    = shl_hi;
                res_we = 1'b1;
                ovf_we = 1'b1;
            end
            OPC_SHR: begin
                res    = shr_hi;
                ovf    = shr_lo;
                res_we = 1'b1;
                ovf_we = 1'b1;
            end
            OPC_TEQ:  cond = (a == b);
            OPC_TNE:  cond = (a != b);
            OPC_TGT:  cond = (a > b);
            OPC_TBIT: cond = ((a & b) != '0);
            default: ;
        endcase
    end

endmodule

// File: rtl/ovw_alu_divider.sv
// Restoring divider: one quotient bit per clock.
// The 2*WIDTH-bit dividend {num, zeros} is divided by den. The upper
// quotient half equals num/den and the lower half equals the fractional
// word ((num<<WIDTH)/den) mod 2^WIDTH. The partial remainder after the
// first WIDTH steps is num%den. A zero divisor gives all-ones quotients,
// which the caller overrides. load is honoured only while idle.
module ovw_alu_divider #(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WIDTH-1:0]  num,
    input  logic [WIDTH-1:0]  den,
    output logic              fin,
    output logic [2*WIDTH-1:0] quot,
    output logic [WIDTH-1:0]  remain
);
    localparam int DW = 2 * WIDTH;
    localparam int CW = $clog2(DW + 1);

    logic [DW-1:0]    acc;
    logic [WIDTH-1:0] part;
    logic [WIDTH-1:0] den_q;
    logic [WIDTH-1:0] rem_q;
    logic [CW-1:0]    step;
    logic             running;
    logic [WIDTH:0]   trial;
    logic             fits;
    logic [WIDTH:0]   part_n;

    // Trial subtraction of the divisor from the shifted partial remainder.
    assign trial  = {part, acc[DW-1]};
    assign fits   = trial >= {1'b0, den_q};
    assign part_n = fits ? (trial - {1'b0, den_q}) : trial;

    // Load operands, run 2*WIDTH steps, then pulse fin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            part    <= '0;
            den_q   <= '0;
            rem_q   <= '0;
            step    <= '0;
            running <= 1'b0;
            fin     <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load && !running) begin
                acc     <= {num, {WIDTH{1'b0}}};
                part    <= '0;
                den_q   <= den;
                step    <= '0;
                running <= 1'b1;
            end else if (running) begin
                acc  <= {acc[DW-2:0], fits};
                part <= part_n[WIDTH-1:0];
                step <= step + 1'b1;
                if (step == CW'(WIDTH - 1)) begin
                    rem_q <= part_n[WIDTH-1:0];
                end
                if (step == CW'(DW - 1)) begin
                    running <= 1'b0;
                    fin     <= 1'b1;
                end
            end
        end
    end

    assign quot   = acc;
    assign remain = rem_q;

endmodule

// File: rtl/ovw_alu.sv
// Top level of the overflow-word ALU.
// Accepts an instruction on start while idle. Single-cycle opcodes are
// registered at once and signalled with done on the next cycle. The two
// divider opcodes hold busy until the divider finishes, and the results
// are registered one cycle later. Assumes the caller holds off new
// instructions until done, or accepts that starts are dropped while busy.
module ovw_alu
    import ovw_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        opcode,
    input  logic [WIDTH-1:0]  op_a,
    input  logic [WIDTH-1:0]  op_b,
    output logic              busy,
    output logic              done,
    output logic [WIDTH-1:0]  result,
    output logic              result_we,
    output logic [WIDTH-1:0]  ovf_word,
    output logic              ovf_we,
    output logic              cond_true,
    output logic [1:0]        cycle_cost
);
    localparam int DW = 2 * WIDTH;

    logic             accept;
    logic             to_div;
    logic [WIDTH-1:0] u_res, u_ovf;
    logic             u_res_we, u_ovf_we, u_cond;
    logic             div_fin;
    logic [DW-1:0]    div_quot;
    logic [WIDTH-1:0] div_rem;
    logic             pend_rem;
    logic             pend_zero;

    assign accept = start && !busy;
    assign to_div = accept && uses_divider(opcode);

    ovw_alu_unit #(.WIDTH(WIDTH)) unit_i (
        .op     (opcode),
        .a      (op_a),
        .b      (op_b),
        .res    (u_res),
        .res_we (u_res_we),
        .ovf    (u_ovf),
        .ovf_we (u_ovf_we),
        .cond   (u_cond)
    );

    ovw_alu_divider #(.WIDTH(WIDTH)) divider_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (to_div),
        .num    (op_a),
        .den    (op_b),
        .fin    (div_fin),
        .quot   (div_quot),
        .remain (div_rem)
    );

    // Register the outputs of single-cycle ops or of a finished division.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            done       <= 1'b0;
            result     <= '0;
            result_we  <= 1'b0;
            ovf_word   <= '0;
            ovf_we     <= 1'b0;
            cond_true  <= 1'b0;
            cycle_cost <= '0;
            pend_rem   <= 1'b0;
            pend_zero  <= 1'b0;
        end else begin
            done      <= 1'b0;
            result_we <= 1'b0;
            ovf_we    <= 1'b0;
            cond_true <= 1'b0;
            if (to_div) begin
                busy       <= 1'b1;
                pend_rem   <= (opcode == OPC_REM);
                pend_zero  <= (op_b == '0);
                cycle_cost <= op_cost(opcode);
            end else if (accept) begin
                done       <= 1'b1;
                result     <= u_res;
                result_we  <= u_res_we;
                ovf_word   <= u_ovf;
                ovf_we     <= u_ovf_we;
                cond_true  <= u_cond;
                cycle_cost <= op_cost(opcode);
            end else if (div_fin) begin
                busy      <= 1'b0;
                done      <= 1'b1;
                result_we <= 1'b1;
                ovf_we    <= !pend_rem;
                if (pend_zero) begin
                    result   <= '0;
                    ovf_word <= '0;
                end else if (pend_rem) begin
                    result   <= div_rem;
                    ovf_word <= '0;
                end else begin
                    result   <= div_quot[DW-1:WIDTH];
                    ovf_word <= div_quot[WIDTH-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/ovw_alu_chk.sv
// Protocol and result checker for ovw_alu, attached with bind.
// Tracks the opcode and divisor of the last accepted instruction.
module ovw_alu_chk
    import ovw_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [3:0]       opcode,
    input logic [WIDTH-1:0] op_b,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] result,
    input logic             result_we,
    input logic [WIDTH-1:0] ovf_word,
    input logic             ovf_we,
    input logic             cond_true,
    input logic [1:0]       cycle_cost
);
    logic [3:0]       op_l;
    logic [WIDTH-1:0] b_l;

    // Remember the opcode and divisor of each accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_l <= '0;
            b_l  <= '0;
        end else if (start && !busy) begin
            op_l <= opcode;
            b_l  <= op_b;
        end
    end

    assert_strobe_needs_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (result_we || ovf_we || cond_true) |-> done);

    assert_single_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && opcode != 4'h5 && opcode != 4'h6) |=> done);

    assert_div_holds_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (opcode == 4'h5 || opcode == 4'h6)) |=> (busy && !done));

    assert_div_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_l == 4'h5 && b_l == '0) |-> (result == '0 && ovf_word == '0));

    assert_cost_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycle_cost == op_cost(op_l)));

    assert_test_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_l >= 4'hC) |-> (!result_we && !ovf_we));

    assert_rem_keeps_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_l == 4'h6) |-> (result_we && !ovf_we));

endmodule

bind ovw_alu ovw_alu_chk #(.WIDTH(WIDTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .opcode     (opcode),
    .op_b       (op_b),
    .busy       (busy),
    .done       (done),
    .result     (result),
    .result_we  (result_we),
    .ovf_word   (ovf_word),
    .ovf_we     (ovf_we),
    .cond_true  (cond_true),
    .cycle_cost (cycle_cost)
);

// File: tb/ovw_alu_tb_top.sv
// Sweep bench for ovw_alu: all opcodes across a grid of corner operands.
// Expected values are computed arithmetically here.
module ovw_alu_tb_top;

    localparam int W       = 16;
    localparam int DIV_LAT = 2 * W + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [3:0]    opcode = '0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic          busy, done, result_we, ovf_we, cond_true;
    logic [W-1:0]  result, ovf_word;
    logic [1:0]    cycle_cost;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ovw_alu #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .op_a(op_a), .op_b(op_b), .busy(busy), .done(done),
        .result(result), .result_we(result_we), .ovf_word(ovf_word),
        .ovf_we(ovf_we), .cond_true(cond_true), .cycle_cost(cycle_cost)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input int op);
        case (op)
            1, 9, 10, 11:   return "R2";
            2, 3:           return "R3";
            4:              return "R4";
            5:              return "R6";
            6:              return "R7";
            7, 8:           return "R5";
            12, 13, 14, 15: return "R8";
            default:        return "R11";
        endcase
    endfunction

    // Reference model written from the requirements.
    task automatic model(input int op, input longint a, input longint b,
                         output longint r, output bit rwe, output longint o,
                         output bit owe, output bit c, output int cost, output int lat);
        r = 0; o = 0; rwe = 0; owe = 0; c = 0; lat = 1;
        case (op)
            1:  begin r = b; rwe = 1; cost = 1; end
            9:  begin r = a & b; rwe = 1; cost = 1; end
            10: begin r = a | b; rwe = 1; cost = 1; end
            11: begin r = a ^ b; rwe = 1; cost = 1; end
            2:  begin r = (a + b) % 65536; o = (a + b > 65535) ? 1 : 0; rwe = 1; owe = 1; cost = 2; end
            3:  begin r = (a - b + 65536) % 65536; o = (b > a) ? 65535 : 0; rwe = 1; owe = 1; cost = 2; end
            4:  begin r = (a * b) % 65536; o = (a * b) / 65536; rwe = 1; owe = 1; cost = 2; end
            7:  begin
                    if (b < 32) begin r = (a << b) % 65536; o = ((a << b) / 65536) % 65536; end
                    rwe = 1; owe = 1; cost = 2;
                end
            8:  begin
                    if (b < 32) begin r = a >> b; o = ((a << 16) >> b) % 65536; end
                    rwe = 1; owe = 1; cost = 2;
                end
            5:  begin
                    if (b != 0) begin r = a / b; o = ((a << 16) / b) % 65536; end
                    rwe = 1; owe = 1; cost = 3; lat = DIV_LAT;
                end
            6:  begin
                    if (b != 0) r = a % b;
                    rwe = 1; cost = 3; lat = DIV_LAT;
                end
            12: begin c = (a == b); cost = 2; end
            13: begin c = (a != b); cost = 2; end
            14: begin c = (a > b); cost = 2; end
            15: begin c = ((a & b) != 0); cost = 2; end
            default: cost = 0;
        endcase
    endtask

    // Issue one instruction, wait for done, compare every output.
    task automatic run(input int op, input int a, input int b);
        longint r, o;
        bit rwe, owe, c;
        int cost, lat, k;
        string t;
        model(op, longint'(a), longint'(b), r, rwe, o, owe, c, cost, lat);
        t = tag_of(op);
        @(negedge clk);
        opcode = op[3:0]; op_a = a[W-1:0]; op_b = b[W-1:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        while (!done && k < 60) begin
            @(negedge clk);
            k++;
        end
        check($sformatf("R10 latency op=%0h", op), k, lat);
        check($sformatf("%s result op=%0h a=%0h b=%0h", t, op, a, b), result, r);
        check($sformatf("%s result_we op=%0h", t, op), result_we, rwe);
        check($sformatf("%s ovf_word op=%0h a=%0h b=%0h", t, op, a, b), ovf_word, o);
        check($sformatf("%s ovf_we op=%0h", t, op), ovf_we, owe);
        check($sformatf("%s cond op=%0h a=%0h b=%0h", t, op, a, b), cond_true, c);
        check($sformatf("R9 cost op=%0h", op), cycle_cost, cost);
    endtask

    int a_set [10] = '{0, 1, 2, 3, 'h7FFF, 'h8000, 'hFFFF, 'h1234, 'hFFFE, 'h00FF};
    int b_set [12] = '{0, 1, 2, 3, 15, 16, 17, 31, 32, 'h8000, 'hFFFF, 'h1234};

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 done", done, 0);
        check("R1 busy", busy, 0);
        check("R1 result", result, 0);
        check("R1 ovf_word", ovf_word, 0);
        check("R1 strobes", {result_we, ovf_we, cond_true}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 12; j++)
                    run(op, a_set[i], b_set[j]);

        // R10: a second start during a division is dropped
        begin
            int k;
            @(negedge clk);
            opcode = 4'h5; op_a = 16'h1234; op_b = 16'd7; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            k = 1;
            check("R10 busy after div start", busy, 1);
            repeat (4) begin @(negedge clk); k++; end
            opcode = 4'h1; op_b = 16'h5555; start = 1'b1;
            @(negedge clk);
            k++;
            start = 1'b0;
            check("R10 no done for dropped start", done, 0);
            while (!done && k < 60) begin
                @(negedge clk);
                k++;
            end
            check("R10 div latency with dropped start", k, DIV_LAT);
            check("R10 div quotient kept", result, 16'h1234 / 7);
            @(negedge clk);
            check("R10 no late done", done, 0);
            check("R10 idle after div", busy, 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule